// File: doc/BRIEF.md
# Banked Data Memory with Peripheral Register Window

This block is the byte-wide data store of a small processor. It holds a 4096-byte address space. A CPU reaches any byte in one of two ways. It can give an 8-bit offset that is combined with a 4-bit bank register held inside the block. It can also supply a complete 12-bit address on an indirect path. The space is split into 16 banks of 256 bytes.

The top 128 addresses (F80h to FFFh) do not hold storage. They form a window onto peripheral control registers. The block routes each access in that window to an external register port. An input mask tells the block which of those 128 locations exist. Everything below F80h is general-purpose RAM, starting at 000h. That RAM is never cleared, so its contents survive any reset.

Top module: `banked_dmem`

## Requirements
- R1: With `ind_sel` low, the effective address is {bank register[3:0], `offset`[7:0]}; the bank register sets address bits 11:8.
- R2: With `ind_sel` high, the effective address is `ind_addr` exactly, and the bank register is ignored.
- R3: `bsr_we` loads `bsr_wdata` into the bank register at the clock edge. `bsr_rdata` returns the register in bits 3:0 with bits 7:4 always zero. Reset clears the register to 0.
- R4: A write to an address below F80h stores `wdata`. A later read of that address returns the stored byte.
- R5: For an address from F80h to FFFh whose mask bit is set, the block drives `sfr_idx` = address[6:0]. A write raises `sfr_wr_en` in that same cycle with `sfr_wdata` = `wdata`. A read raises `sfr_rd_en` and returns the `sfr_rdata` value sampled in that cycle.
- R6: A read of a window address whose bit in `sfr_impl` (indexed by address[6:0]) is clear returns 00h.
- R7: A write to an unimplemented window address leaves `sfr_wr_en` low and changes nothing. No access to such an address raises either port strobe.
- R8: Read data appears on `rdata` one cycle after the address is presented with `rd_en`. When `rd_en` is low, `rdata` holds its value.
- R9: Reset does not change RAM contents.
- R10: Reset clears `rdata` to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bsr_we | input | 1 | Load the bank register |
| bsr_wdata | input | 4 | New bank number |
| bsr_rdata | output | 8 | Bank register, zero-extended |
| ind_sel | input | 1 | Use the full indirect address |
| ind_addr | input | 12 | Indirect address |
| offset | input | 8 | In-bank offset for banked access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sfr_impl | input | 128 | Mask of implemented window locations |
| sfr_idx | output | 7 | Window location index |
| sfr_rd_en | output | 1 | Read strobe to the register port |
| sfr_wr_en | output | 1 | Write strobe to the register port |
| sfr_wdata | output | 8 | Write data to the register port |
| sfr_rdata | input | 8 | Read data from the register port |

## Verification
The hardest case is a write that lands on a hole in the window. Its only visible sign is a strobe that stays low. A later read returns zero no matter what was written, so reading back alone cannot show whether the write leaked. The stimulus writes a distinct pattern to every one of the 4096 addresses through the banked path, with the mask set to a sparse pattern. At each window address it observes the port strobe in the same cycle. It then reads the whole space back through the indirect path, and after that repeats the exercise with the two paths swapped. A reset is pulsed between sweeps to show that RAM keeps its contents.

// File: rtl/banked_dmem.sv
`timescale 1ns/1ps
module banked_dmem #(
  parameter int BANK_W = 4,
  parameter int OFF_W  = 8,
  parameter int DW     = 8,
  parameter int SFR_N  = 128,
  parameter int AW     = BANK_W + OFF_W,
  parameter int SFR_IW = $clog2(SFR_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bsr_we,
  input  logic [BANK_W-1:0] bsr_wdata,
  output logic [DW-1:0]     bsr_rdata,
  input  logic              ind_sel,
  input  logic [AW-1:0]     ind_addr,
  input  logic [OFF_W-1:0]  offset,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [SFR_N-1:0]  sfr_impl,
  output logic [SFR_IW-1:0] sfr_idx,
  output logic              sfr_rd_en,
  output logic              sfr_wr_en,
  output logic [DW-1:0]     sfr_wdata,
  input  logic [DW-1:0]     sfr_rdata
);
  localparam int RAM_N = (1 << AW) - SFR_N;
  localparam logic [AW-1:0] SFR_BASE = AW'(RAM_N);

  logic [BANK_W-1:0] bsr;
  logic [DW-1:0]     ram [RAM_N];

  wire [AW-1:0] eff    = ind_sel ? ind_addr : {bsr, offset};
  wire          in_sfr = eff >= SFR_BASE;
  wire          impl   = sfr_impl[eff[SFR_IW-1:0]];

  assign bsr_rdata = {{(DW-BANK_W){1'b0}}, bsr};
  assign sfr_idx   = eff[SFR_IW-1:0];
  assign sfr_rd_en = rd_en & in_sfr & impl;
  assign sfr_wr_en = wr_en & in_sfr & impl;
  assign sfr_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bsr <= '0;
    else if (bsr_we) bsr <= bsr_wdata;

  always_ff @(posedge clk)
    if (wr_en && !in_sfr) ram[eff] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= !in_sfr ? ram[eff] : (impl ? sfr_rdata : '0);
endmodule

// File: rtl/banked_dmem_chk.sv
`timescale 1ns/1ps
module banked_dmem_chk #(
  parameter int BANK_W = 4,
  parameter int OFF_W  = 8,
  parameter int DW     = 8,
  parameter int SFR_N  = 128,
  parameter int AW     = BANK_W + OFF_W,
  parameter int SFR_IW = $clog2(SFR_N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bsr_we,
  input logic [BANK_W-1:0] bsr_wdata,
  input logic [DW-1:0]     bsr_rdata,
  input logic              ind_sel,
  input logic [AW-1:0]     ind_addr,
  input logic [OFF_W-1:0]  offset,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic [SFR_N-1:0]  sfr_impl,
  input logic [SFR_IW-1:0] sfr_idx,
  input logic              sfr_rd_en,
  input logic              sfr_wr_en,
  input logic [DW-1:0]     sfr_wdata,
  input logic [DW-1:0]     sfr_rdata
);
  localparam logic [AW-1:0] BASE = AW'((1 << AW) - SFR_N);
  wire [AW-1:0] ea  = ind_sel ? ind_addr : {bsr_rdata[BANK_W-1:0], offset};
  wire          win = ea >= BASE;
  wire          imp = sfr_impl[ea[SFR_IW-1:0]];

  AST_BANK_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_rdata[DW-1:BANK_W] == '0);                                           // R3
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_we |=> bsr_rdata[BANK_W-1:0] == $past(bsr_wdata));                   // R3
  AST_STROBE_ONLY_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd_en || sfr_wr_en) |-> (win && imp));                              // R7
  AST_STROBE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd_en || sfr_wr_en) |-> sfr_idx == ea[SFR_IW-1:0]);                 // R5
  AST_SFR_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && win && imp) |=> rdata == $past(sfr_rdata));                    // R5
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && win && !imp) |=> rdata == '0);                                 // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));                                              // R8
endmodule

bind banked_dmem banked_dmem_chk #(
  .BANK_W(BANK_W), .OFF_W(OFF_W), .DW(DW), .SFR_N(SFR_N)
) u_chk (.*);

// File: tb/sim_banked_dmem.sv
`timescale 1ns/1ps
module sim_banked_dmem;
  logic clk = 0, rst_n = 0;
  logic bsr_we = 0, ind_sel = 0, rd_en = 0, wr_en = 0;
  logic [3:0] bsr_wdata = 0;
  logic [7:0] bsr_rdata, offset = 0, wdata = 0, rdata, sfr_wdata, sfr_rdata;
  logic [11:0] ind_addr = 0;
  logic [127:0] sfr_impl;
  logic [6:0] sfr_idx;
  logic sfr_rd_en, sfr_wr_en;
  logic [7:0] per [128];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  banked_dmem u0 (.*);

  assign sfr_rdata = per[sfr_idx];
  always @(posedge clk) if (sfr_wr_en) per[sfr_idx] <= sfr_wdata;

  function automatic logic [7:0] pat(input logic [11:0] a, input bit second);
    logic [7:0] v = a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    return second ? ~v : v;
  endfunction

  function automatic logic [7:0] expect_rd(input logic [11:0] a, input bit second);
    if (a < 12'hF80) return pat(a, second);
    return sfr_impl[a[6:0]] ? pat(a, second) : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_bank(input logic [3:0] b);
    @(negedge clk); bsr_we = 1; bsr_wdata = b;
    @(negedge clk); bsr_we = 0;
    chk("R3 bank readback", 32'(bsr_rdata), {28'h0, b});
  endtask

  task automatic wr(input bit ind, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    ind_sel = ind; ind_addr = ind ? a : 12'h0; offset = a[7:0];
    wr_en = 1; wdata = d;
    #1;
    if (a >= 12'hF80) begin
      if (sfr_impl[a[6:0]]) begin
        chk("R5 write strobe", 32'(sfr_wr_en), 1);
        chk("R5 index", 32'(sfr_idx), 32'(a[6:0]));
      end else
        chk("R7 hole write strobe", 32'({sfr_wr_en, sfr_rd_en}), 0);
    end else
      chk("R4 no port strobe for RAM", 32'(sfr_wr_en), 0);
  endtask

  task automatic rd(input bit ind, input logic [11:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    wr_en = 0; ind_sel = ind; ind_addr = ind ? a : 12'h0; offset = a[7:0]; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk(req, 32'(rdata), 32'(e));
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      sfr_impl[i] = (i % 3) != 0;
      per[i] = 8'hA5;
    end
    @(negedge clk); @(negedge clk);
    chk("R10 rdata reset", 32'(rdata), 0);
    chk("R3 bank reset", 32'(bsr_rdata), 0);
    rst_n = 1;

    // banked writes (R1), indirect reads (R2)
    for (int b = 0; b < 16; b++) begin
      set_bank(4'(b));
      for (int o = 0; o < 256; o++) wr(0, 12'(b * 256 + o), pat(12'(b * 256 + o), 0));
    end
    @(negedge clk); wr_en = 0;
    for (int a = 0; a < 4096; a++) begin
      if (a < 12'hF80) rd(1, 12'(a), expect_rd(12'(a), 0), "R1 R4 banked write / indirect read");
      else if (sfr_impl[a % 128]) rd(1, 12'(a), expect_rd(12'(a), 0), "R5 window read");
      else rd(1, 12'(a), 8'h00, "R6 hole reads zero");
    end

    // R2: bank register must not influence indirect access
    set_bank(4'h3);
    for (int a = 0; a < 4096; a++) wr(1, 12'(a), pat(12'(a), 1));
    @(negedge clk); wr_en = 0;

    // R8: hold while rd_en low
    rd(0, 12'h305, pat(12'h305, 1), "R1 R2 indirect write / banked read");
    @(negedge clk); offset = 8'h10; ind_sel = 1; ind_addr = 12'h000;
    @(negedge clk); @(negedge clk);
    chk("R8 rdata holds", 32'(rdata), 32'(pat(12'h305, 1)));

    // R9/R10: reset keeps RAM
    rst_n = 0;
    @(negedge clk);
    chk("R10 rdata reset", 32'(rdata), 0);
    chk("R3 bank reset", 32'(bsr_rdata), 0);
    rst_n = 1;

    for (int b = 0; b < 16; b++) begin
      set_bank(4'(b));
      for (int o = 0; o < 256; o++)
        rd(0, 12'(b * 256 + o), expect_rd(12'(b * 256 + o), 1), "R9 R1 banked readback after reset");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule